// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into an SRAM-based programmable device over a passive serial link. On a start pulse it runs the power-up handshake. It holds the neighbouring bus in reset and strobes the device's active-low configuration request. It then waits for the device to acknowledge on its active-low status line and, later, to report that it is ready. After that it clocks the bytes it receives on a valid/ready stream into the device one bit per serial clock.

When the stream's last byte has gone out, the block keeps clocking zero bits until the device raises its done flag. It then gives a fixed burst of further clocks so the device enters user mode, and releases the bus reset. Three distinct failures end the run with a coded error: the device never becomes ready, the done flag never rises, or the status line collapses while data is moving. In every failure the bus stays in reset and the configuration request stays low.

The serial clock comes from a phase counter on the system clock. Its low and high phase lengths are parameters, so data setup and hold at the device are set directly in system cycles. All delays and timeouts are counted in system cycles, and the status and done pins pass through a two-flop synchroniser.

Top module: `pscfg_seq`

## Requirements
- R1: `bus_rst_n_o` is low from reset and through every run; it goes high only on success and returns low when a new run starts.
- R2: After a start pulse, `cfg_n_o` stays high for exactly LONG_DLY cycles. It then goes low for at least SHORT_DLY cycles, and rises again only after the synchronised status line has been seen low.
- R3: If the status line is not high within READY_TMO cycles after the configuration request is released, the run ends with `err_o` high and `err_code_o` = 1. No serial clock has been issued, and `cfg_n_o` is left low.
- R4: Each byte is sent least significant bit first, one bit per rising edge of `cclk_o`, eight clocks per byte. `cdata_o` changes only while `cclk_o` is low and is stable while it is high.
- R5: `s_ready` is high only during the data phase, when the shifter is empty or its eighth bit period is ending. It is low before the device is ready. A byte with `s_last` high is the final one accepted.
- R6: After the final byte, zero bits are clocked until the done input is seen high. Exactly TAIL_CLKS (default 10) further zero-data clocks follow, and then `ok_o` rises. No clock follows completion.
- R7: If the done input is not seen high within DONE_TMO cycles of the data phase ending, the run ends with `err_o` high and `err_code_o` = 2.
- R8: If the status line goes low during the data phase, the run ends within four cycles with `err_o` high and `err_code_o` = 3, and the serial clock stops.
- R9: `busy_o` is high from the start pulse until success or error. `ok_o` and `err_o` are never both high, and a start pulse after an error or a success begins a fresh run.
- R10: After reset `cfg_n_o` is high, `cclk_o`, `cdata_o`, `busy_o`, `ok_o`, `err_o` and `s_ready` are low, and `err_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a configuration run |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Stream byte accepted this cycle when high with s_valid |
| status_n_i | input | 1 | Device status, active low, asynchronous |
| done_i | input | 1 | Device configuration-done flag, asynchronous |
| cfg_n_o | output | 1 | Configuration request to the device, active low |
| cdata_o | output | 1 | Serial configuration data |
| cclk_o | output | 1 | Serial configuration clock |
| bus_rst_n_o | output | 1 | Reset to the attached bus, active low |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Last run completed successfully |
| err_o | output | 1 | Last run ended with an error |
| err_code_o | output | 2 | 0 none, 1 ready timeout, 2 done timeout, 3 status lost |

## Verification
A wrong shift pointer or shift register shows at the next rising serial clock as a data bit that differs from the scoreboard's LSB-first expectation. A wrong padding or tail count shows as a surplus or missing clock once `ok_o` rises. A sequencer stuck in the wrong handshake phase shows within a few cycles as a misplaced `cfg_n_o` edge, a premature `s_ready`, or a wrong error code. The most delayed symptom is a timeout counter that clears or compares wrongly: it shows only when the timeout would have expired, as an error that arrives too early or too late.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_PULSE,
      ST_ACK,
      ST_READY,
      ST_DATA,
      ST_PAD,
      ST_TAIL,
      ST_OK,
      ST_FAIL
   } pscfg_state_e;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_READY = 2'd1,
      ERR_DONE  = 2'd2,
      ERR_LOST  = 2'd3
   } pscfg_err_e;

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
   parameter int               WIDTH   = 2,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pscfg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pscfg_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pscfg_ccgen.sv
module pscfg_ccgen #(
   parameter int LOW_CYC  = 4,
   parameter int HIGH_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic cclk,
   output logic ph_end
);

   localparam int PERIOD = LOW_CYC + HIGH_CYC;
   localparam int PW     = $clog2(PERIOD);
   localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
   localparam logic [PW-1:0] PH_RISE = PW'(LOW_CYC);

   if (LOW_CYC < 1 || HIGH_CYC < 1) begin : g_bad_phase
      $error("pscfg_ccgen: both clock phases need at least one cycle");
   end

   logic [PW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!run || ph == PH_LAST) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign cclk   = run && (ph >= PH_RISE);
   assign ph_end = run && (ph == PH_LAST);

   AST_CC_FALL_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ph_end) |-> !cclk) else $error("serial clock high after period end"); // R4

endmodule

// File: rtl/pscfg_seq.sv
module pscfg_seq
   import pscfg_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LONG_DLY  = 10000,
   parameter int SHORT_DLY = 100,
   parameter int READY_TMO = 100000,
   parameter int DONE_TMO  = 1000000,
   parameter int LOW_CYC   = 4,
   parameter int HIGH_CYC  = 4,
   parameter int TAIL_CLKS = 10,
   parameter int SYNC_STG  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          s_valid,
   input  logic [DW-1:0] s_data,
   input  logic          s_last,
   output logic          s_ready,
   input  logic          status_n_i,
   input  logic          done_i,
   output logic          cfg_n_o,
   output logic          cdata_o,
   output logic          cclk_o,
   output logic          bus_rst_n_o,
   output logic          busy_o,
   output logic          ok_o,
   output logic          err_o,
   output logic [1:0]    err_code_o
);

   localparam int MAX_A   = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
   localparam int MAX_B   = (READY_TMO > DONE_TMO) ? READY_TMO : DONE_TMO;
   localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int BW      = $clog2(DW);
   localparam int TW      = $clog2(TAIL_CLKS + 1);
   localparam logic [CW-1:0] LONG_M1  = CW'(LONG_DLY - 1);
   localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_DLY - 1);
   localparam logic [CW-1:0] RDY_M1   = CW'(READY_TMO - 1);
   localparam logic [CW-1:0] DONE_M1  = CW'(DONE_TMO - 1);
   localparam logic [BW-1:0] BI_LAST  = BW'(DW - 1);
   localparam logic [TW-1:0] TAIL_M1  = TW'(TAIL_CLKS - 1);

   if (DW < 2) begin : g_bad_dw
      $error("pscfg_seq: DW must be at least 2");
   end
   if (LONG_DLY < 1 || SHORT_DLY < 1 || READY_TMO < 1 || DONE_TMO < 1) begin : g_bad_dly
      $error("pscfg_seq: delays and timeouts must be at least 1");
   end
   if (TAIL_CLKS < 1) begin : g_bad_tail
      $error("pscfg_seq: TAIL_CLKS must be at least 1");
   end

   pscfg_state_e  state;
   pscfg_err_e    err_q;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh;
   logic [BW-1:0] bit_idx;
   logic [TW-1:0] tail_cnt;
   logic          have_byte;
   logic          last_taken;
   logic          stat_n_s;
   logic          done_s;
   logic          run;
   logic          ph_end;
   logic          take;

   pscfg_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(2'b10)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({status_n_i, done_i}),
      .q     ({stat_n_s, done_s})
   );

   assign run = (state == ST_DATA && have_byte) || state == ST_PAD || state == ST_TAIL;

   pscfg_ccgen #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) i_ccgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .cclk   (cclk_o),
      .ph_end (ph_end)
   );

   assign s_ready = (state == ST_DATA) && stat_n_s && !last_taken &&
                    (!have_byte || (bit_idx == BI_LAST && ph_end));
   assign take    = s_valid && s_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         err_q      <= ERR_NONE;
         cnt        <= '0;
         sh         <= '0;
         bit_idx    <= '0;
         tail_cnt   <= '0;
         have_byte  <= 1'b0;
         last_taken <= 1'b0;
      end else if (start && state inside {ST_IDLE, ST_OK, ST_FAIL}) begin
         state      <= ST_PRE;
         err_q      <= ERR_NONE;
         cnt        <= '0;
         have_byte  <= 1'b0;
         last_taken <= 1'b0;
      end else begin
         case (state)
            ST_PRE: begin
               if (cnt == LONG_M1) begin
                  state <= ST_PULSE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PULSE: begin
               if (cnt == SHORT_M1) begin
                  state <= ST_ACK;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ACK: begin
               if (!stat_n_s) begin
                  state <= ST_READY;
                  cnt   <= '0;
               end
            end
            ST_READY: begin
               if (stat_n_s) begin
                  state <= ST_DATA;
                  cnt   <= '0;
               end else if (cnt == RDY_M1) begin
                  state <= ST_FAIL;
                  err_q <= ERR_READY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (!stat_n_s) begin
                  state     <= ST_FAIL;
                  err_q     <= ERR_LOST;
                  have_byte <= 1'b0;
               end else if (take) begin
                  sh         <= s_data;
                  bit_idx    <= '0;
                  have_byte  <= 1'b1;
                  last_taken <= s_last;
               end else if (ph_end) begin
                  if (bit_idx == BI_LAST) begin
                     have_byte <= 1'b0;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     sh      <= sh >> 1;
                  end
               end else if (!have_byte && last_taken) begin
                  state <= ST_PAD;
                  cnt   <= '0;
               end
            end
            ST_PAD: begin
               if (ph_end && done_s) begin
                  state    <= ST_TAIL;
                  tail_cnt <= '0;
               end else if (cnt == DONE_M1) begin
                  state <= ST_FAIL;
                  err_q <= ERR_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_TAIL: begin
               if (ph_end) begin
                  if (tail_cnt == TAIL_M1) begin
                     state <= ST_OK;
                  end else begin
                     tail_cnt <= tail_cnt + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign cdata_o     = (state == ST_DATA && have_byte) ? sh[0] : 1'b0;
   assign cfg_n_o     = !(state inside {ST_PULSE, ST_ACK, ST_FAIL});
   assign bus_rst_n_o = (state == ST_OK);
   assign busy_o      = !(state inside {ST_IDLE, ST_OK, ST_FAIL});
   assign ok_o        = (state == ST_OK);
   assign err_o       = (state == ST_FAIL);
   assign err_code_o  = err_q;

   AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !bus_rst_n_o) else $error("bus reset released during run"); // R1
   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk_o && $past(cclk_o)) |-> $stable(cdata_o)) else $error("data moved while clock high"); // R4
   AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (have_byte && bit_idx == '0)) else $error("accepted byte not loaded"); // R5
   AST_FAIL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!cfg_n_o && !bus_rst_n_o && err_code_o != ERR_NONE)) else $error("error state pins wrong"); // R3
   AST_OK_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> ($past(cclk_o) && !$past(cdata_o))) else $error("success not after zero clock"); // R6
   AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && err_o)) else $error("ok and error together"); // R9

endmodule

// File: tb/test_pscfg_seq.sv
module test_pscfg_seq;

   localparam int LONG  = 20;
   localparam int SHORT = 8;
   localparam int TAILN = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       s_valid = 1'b0;
   logic [7:0] s_data = '0;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       status_n = 1'b1;
   logic       done_pin = 1'b0;
   logic       cfg_n_o, cdata_o, cclk_o, bus_rst_n_o, busy_o, ok_o, err_o;
   logic [1:0] err_code_o;

   int n_chk = 0;
   int n_fail = 0;

   bit   exp_q[$];
   int   run_rises = 0;
   int   data_bits = 0;
   int   pad_target = 0;
   bit   accept_pad = 0;
   bit   block_ready = 0;
   bit   drop_stat = 0;
   int   ready_lat = 5;
   logic [7:0] tx_buf[8];
   int   tx_n = 0;

   always #4 clk = ~clk;

   pscfg_seq #(
      .DW(8), .LONG_DLY(LONG), .SHORT_DLY(SHORT), .READY_TMO(100), .DONE_TMO(200),
      .LOW_CYC(3), .HIGH_CYC(4), .TAIL_CLKS(TAILN), .SYNC_STG(2)
   ) i_pscfg_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .status_n_i(status_n), .done_i(done_pin),
      .cfg_n_o(cfg_n_o), .cdata_o(cdata_o), .cclk_o(cclk_o), .bus_rst_n_o(bus_rst_n_o),
      .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_code_o(err_code_o)
   );

   task automatic check(input bit cond, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   // device model: status follows the configuration request
   initial begin
      int hi_cnt;
      hi_cnt = 0;
      forever begin
         @(negedge clk);
         if (!cfg_n_o) begin
            status_n = 1'b0;
            hi_cnt   = 0;
         end else if (drop_stat) begin
            status_n = 1'b0;
         end else if (!status_n && !block_ready) begin
            hi_cnt++;
            if (hi_cnt >= ready_lat) status_n = 1'b1;
         end
      end
   end

   // monitor: pops expected bits at each serial clock rise, raises done
   initial begin
      logic prev;
      prev = 1'b0;
      forever begin
         @(negedge clk);
         if (cclk_o && !prev) begin
            run_rises++;
            if (exp_q.size() > 0) begin
               bit e;
               e = exp_q.pop_front();
               check(cdata_o == e, "R4", "serial bit", int'(cdata_o), int'(e));
            end else if (accept_pad) begin
               check(cdata_o == 1'b0, "R7", "pad bit", int'(cdata_o), 0);
            end else begin
               check(1'b0, "R6", "surplus serial clock", run_rises, run_rises - 1);
            end
            if (pad_target != 0 && run_rises == data_bits + pad_target) done_pin = 1'b1;
         end
         prev = cclk_o;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic prep_run(input int nbits, input int pad);
      done_pin   = 1'b0;
      run_rises  = 0;
      data_bits  = nbits;
      pad_target = pad;
      exp_q.delete();
   endtask

   task automatic send_bytes(input int gap);
      for (int i = 0; i < tx_n; i++) begin
         for (int k = 0; k < 8; k++) exp_q.push_back(tx_buf[i][k]);
         s_valid = 1'b1;
         s_data  = tx_buf[i];
         s_last  = (i == tx_n - 1);
         while (!s_ready && !err_o) @(negedge clk);
         @(negedge clk);
         s_valid = 1'b0;
         s_last  = 1'b0;
         if (err_o) break;
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
   endtask

   task automatic push_zeros(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
   endtask

   task automatic wait_end(input int limit);
      int c;
      c = 0;
      while (busy_o && c < limit) begin
         @(negedge clk);
         c++;
      end
   endtask

   task automatic check_success(input string tag);
      check(ok_o == 1'b1, "R6", {tag, " ok"}, int'(ok_o), 1);
      check(err_o == 1'b0 && err_code_o == 2'd0, "R9", {tag, " no error"}, int'(err_code_o), 0);
      check(bus_rst_n_o == 1'b1, "R1", {tag, " bus reset released"}, int'(bus_rst_n_o), 1);
      check(exp_q.size() == 0, "R6", {tag, " clocks outstanding"}, exp_q.size(), 0);
      repeat (20) @(negedge clk);
      check(cclk_o == 1'b0 && exp_q.size() == 0, "R6", {tag, " quiet after ok"}, int'(cclk_o), 0);
   endtask

   initial begin
      int c;
      repeat (5) @(negedge clk);
      s_valid = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(cfg_n_o == 1'b1, "R10", "cfg_n after reset", int'(cfg_n_o), 1);
      check(!cclk_o && !cdata_o, "R10", "serial pins after reset", int'({cclk_o, cdata_o}), 0);
      check(!busy_o && !ok_o && !err_o, "R10", "flags after reset", int'({busy_o, ok_o, err_o}), 0);
      check(err_code_o == 2'd0, "R10", "code after reset", int'(err_code_o), 0);
      check(bus_rst_n_o == 1'b0, "R1", "bus reset held in reset", int'(bus_rst_n_o), 0);
      check(s_ready == 1'b0, "R10", "s_ready in reset", int'(s_ready), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(s_ready == 1'b0, "R5", "s_ready idle with valid", int'(s_ready), 0);
      s_valid = 1'b0;

      // run A: three bytes with gaps, pad 5
      ready_lat = 5;
      prep_run(24, 5);
      pulse_start();
      check(busy_o == 1'b1, "R9", "busy after start", int'(busy_o), 1);
      check(bus_rst_n_o == 1'b0, "R1", "bus reset during run", int'(bus_rst_n_o), 0);
      c = 0;
      while (cfg_n_o && c < 1000) begin c++; @(negedge clk); end
      check(c == LONG, "R2", "cfg_n high span", c, LONG);
      c = 0;
      while (!cfg_n_o && c < 1000) begin c++; @(negedge clk); end
      check(c >= SHORT && c <= SHORT + 4, "R2", "cfg_n low span", c, SHORT);
      check(s_ready == 1'b0, "R5", "s_ready before ready", int'(s_ready), 0);
      tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'h01; tx_n = 3;
      send_bytes(5);
      push_zeros(5 + TAILN);
      wait_end(3000);
      check_success("runA");

      // run B: four bytes back to back, pad 1
      prep_run(32, 1);
      pulse_start();
      check(bus_rst_n_o == 1'b0, "R1", "bus reset reasserted on restart", int'(bus_rst_n_o), 0);
      tx_buf[0] = 8'hFF; tx_buf[1] = 8'h00; tx_buf[2] = 8'h80; tx_buf[3] = 8'h7E; tx_n = 4;
      send_bytes(0);
      push_zeros(1 + TAILN);
      wait_end(3000);
      check_success("runB");

      // run C: device never ready
      block_ready = 1'b1;
      prep_run(0, 0);
      pulse_start();
      wait_end(3000);
      check(err_o == 1'b1 && err_code_o == 2'd1, "R3", "ready timeout code", int'(err_code_o), 1);
      check(cfg_n_o == 1'b0, "R3", "cfg_n left low", int'(cfg_n_o), 0);
      check(run_rises == 0, "R3", "no serial clock", run_rises, 0);
      check(bus_rst_n_o == 1'b0 && !ok_o, "R1", "bus reset held on error", int'(bus_rst_n_o), 0);
      block_ready = 1'b0;

      // run D: done never rises
      prep_run(8, 0);
      accept_pad = 1'b1;
      pulse_start();
      tx_buf[0] = 8'h96; tx_n = 1;
      send_bytes(0);
      wait_end(3000);
      check(err_o == 1'b1 && err_code_o == 2'd2, "R7", "done timeout code", int'(err_code_o), 2);
      check(run_rises > 8, "R7", "pad clocks issued", run_rises, 9);
      check(exp_q.size() == 0, "R4", "data bits of run D", exp_q.size(), 0);
      accept_pad = 1'b0;

      // run E: status lost mid transfer
      prep_run(16, 5);
      pulse_start();
      tx_buf[0] = 8'hC3; tx_buf[1] = 8'h5A; tx_n = 2;
      fork
         send_bytes(0);
      join_none
      c = 0;
      while (run_rises < 4 && c < 3000) begin c++; @(negedge clk); end
      drop_stat = 1'b1;
      c = 0;
      while (!err_o && c < 50) begin c++; @(negedge clk); end
      check(c <= 4, "R8", "abort latency", c, 3);
      check(err_code_o == 2'd3, "R8", "status lost code", int'(err_code_o), 3);
      c = run_rises;
      repeat (20) @(negedge clk);
      check(run_rises == c && !cclk_o, "R8", "clock stopped", run_rises, c);
      drop_stat = 1'b0;
      repeat (5) @(negedge clk);
      exp_q.delete();

      // run F: restart after error
      prep_run(8, 2);
      pulse_start();
      check(busy_o == 1'b1 && !err_o, "R9", "restart from error", int'(busy_o), 1);
      tx_buf[0] = 8'h5A; tx_n = 1;
      send_bytes(0);
      push_zeros(2 + TAILN);
      wait_end(3000);
      check_success("runF");

      summary();
      $finish;
   end

endmodule